// File: doc/BRIEF.md
# Execution Unit Error Detection Controller

This block sits beside a data-processing execution unit and watches two things: the register bus that software uses to program the unit, and the push, pop, full and empty signals of the unit's input and output FIFOs. It recognises nine error conditions. Some come from raw FIFO events, such as a pop while empty or a push while full. Others depend on protocol context: the output FIFO still holding data when a new data size is programmed, or the input FIFO still holding data when the unit reports completion.

Each error has a bit in a 64-bit status register and a matching bit in a mask register. A masked error is dropped and leaves no trace. An unmasked error sets its sticky status bit. Any set status bit drives the error interrupt and the halt request to the execution unit. Software clears status bits by writing ones to the status register address. The block also keeps its own count of 64-bit words in the input FIFO. Under host-controlled loading it treats any push beyond 256 bytes as an overflow, even if the FIFO's own full flag is low.

Top module: `eu_err_ctrl`

## Requirements
- R1: After reset, `status`, `err_irq` and `halt` are all zero and no error is masked.
- R2: A write to the size register (address 0x08) whose data has any of bits 5..0 set sets status bit 55 (data size not a whole number of 64-bit blocks). A write of a multiple of 64 sets nothing.
- R3: A write to the mode register (address 0x00) sets status bit 56 if any bit 63..3 is set or if the 3-bit mode field in bits 2..0 exceeds 4.
- R4: A read or write to any address other than 0x00, 0x08, 0x10 and 0x18 sets status bit 57. An access to one of those four addresses does not.
- R5: A write to the size register while `out_empty` is low sets status bit 58.
- R6: A `done` pulse while `in_empty` is low sets status bit 59. A `done` pulse with the input FIFO empty sets nothing.
- R7: `in_pop` while `in_empty` is high sets bit 60. `out_pop` while `out_empty` is high sets bit 62.
- R8: `in_push` while `in_full` is high sets bit 61. `out_push` while `out_full` is high sets bit 63.
- R9: The block counts input words: a push that is not an overflow adds one, and `in_pop` with `in_empty` low and a nonzero count removes one. A push that finds 32 words (256 bytes) already counted sets bit 61.
- R10: Writing the mask register (address 0x10) stores write-data bits 63..55. From the next cycle on, an error whose mask bit is set changes neither `status` nor `err_irq`.
- R11: Status bits are sticky. A write to address 0x18 clears each status bit whose write-data bit is one. A new error in the same cycle wins over the clear.
- R12: `err_irq` and `halt` are high exactly while any status bit is set. Status bits 54..0 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Register write data |
| in_push | input | 1 | Input FIFO push strobe |
| in_pop | input | 1 | Input FIFO pop strobe |
| in_full | input | 1 | Input FIFO full flag |
| in_empty | input | 1 | Input FIFO empty flag |
| out_push | input | 1 | Output FIFO push strobe |
| out_pop | input | 1 | Output FIFO pop strobe |
| out_full | input | 1 | Output FIFO full flag |
| out_empty | input | 1 | Output FIFO empty flag |
| done | input | 1 | Completion pulse from the execution unit |
| status | output | 64 | Sticky error status register |
| err_irq | output | 1 | Error interrupt |
| halt | output | 1 | Stop request to the execution unit |

## Verification
Every error is registered on the clock edge that samples its stimulus. Its status bit, `err_irq` and `halt` are therefore due one cycle after the stimulus. A mask or clear write takes effect for events in the following cycle. The bench changes inputs on the falling edge and holds each stimulus for exactly one rising edge. It reads the outputs at the next falling edge, so every check lands in the first cycle the result is due. For sticky behaviour, the bench also reads again after idle cycles.

// File: rtl/eu_err_pkg.sv
// Package: shared constants and types for the error detection controller.
// Assumes the nine error flags occupy the top bits of a 64-bit status word.
package eu_err_pkg;
    localparam int STAT_W  = 64;
    localparam int ERR_N   = 9;
    localparam int ERR_LSB = STAT_W - ERR_N;   // 55

    // Index of each error within the error vector (status bit = ERR_LSB + index)
    localparam int IX_DSE = 0;   // size not block aligned
    localparam int IX_ME  = 1;   // illegal mode
    localparam int IX_AE  = 2;   // undecoded address
    localparam int IX_OFE = 3;   // output FIFO busy at size write
    localparam int IX_IFE = 4;   // input FIFO busy at done
    localparam int IX_IFU = 5;   // input underflow
    localparam int IX_IFO = 6;   // input overflow
    localparam int IX_OFU = 7;   // output underflow
    localparam int IX_OFO = 8;   // output overflow

    typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/eu_reg_decode.sv
// Module: register bus decoder. Flags size, mode and address errors and
// produces write enables for the size, mask and clear registers.
// Assumes single-cycle strobes and that the four decoded addresses are distinct.
module eu_reg_decode #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int MODE_W   = 3,
    parameter int MODE_MAX = 4,
    parameter int BLK_BITS = 64,
    parameter logic [ADDR_W-1:0] A_MODE = 'h00,
    parameter logic [ADDR_W-1:0] A_SIZE = 'h08,
    parameter logic [ADDR_W-1:0] A_MASK = 'h10,
    parameter logic [ADDR_W-1:0] A_STAT = 'h18
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              err_dse,
    output logic              err_me,
    output logic              err_ae,
    output logic              size_we,
    output logic              mask_we,
    output logic              clr_we
);
    localparam int BLK_LSB = $clog2(BLK_BITS);
    localparam logic [MODE_W-1:0] MODE_LIM = MODE_W'(MODE_MAX);

    logic hit_mode, hit_size, hit_mask, hit_stat, known;

    // Address match and error classification for the current bus cycle
    always_comb begin
        hit_mode = (reg_addr == A_MODE);
        hit_size = (reg_addr == A_SIZE);
        hit_mask = (reg_addr == A_MASK);
        hit_stat = (reg_addr == A_STAT);
        known    = hit_mode | hit_size | hit_mask | hit_stat;
        err_ae   = (reg_wr | reg_rd) & ~known;
        size_we  = reg_wr & hit_size;
        mask_we  = reg_wr & hit_mask;
        clr_we   = reg_wr & hit_stat;
        err_dse  = size_we & (|reg_wdata[BLK_LSB-1:0]);
        err_me   = reg_wr & hit_mode &
                   ((|reg_wdata[DATA_W-1:MODE_W]) | (reg_wdata[MODE_W-1:0] > MODE_LIM));
    end
endmodule

// File: rtl/eu_fifo_monitor.sv
// Module: FIFO event monitor. Flags underflow, overflow and the two context
// errors, and tracks input FIFO occupancy against the host-mode capacity.
// Assumes one push and one pop strobe per FIFO per cycle, in units of one word.
module eu_fifo_monitor #(
    parameter int IN_CAP_BYTES = 256,
    parameter int WORD_BYTES   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_push,
    input  logic in_pop,
    input  logic in_full,
    input  logic in_empty,
    input  logic out_push,
    input  logic out_pop,
    input  logic out_full,
    input  logic out_empty,
    input  logic done,
    input  logic size_we,
    output logic err_ifu,
    output logic err_ifo,
    output logic err_ofu,
    output logic err_ofo,
    output logic err_ofe,
    output logic err_ife
);
    localparam int DEPTH = IN_CAP_BYTES / WORD_BYTES;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level_q;
    logic             inc, dec;

    // Error detection from strobes, flags and the occupancy count
    always_comb begin
        err_ifo = in_push & (in_full | (level_q == LVL_TOP));
        err_ifu = in_pop & in_empty;
        err_ofo = out_push & out_full;
        err_ofu = out_pop & out_empty;
        err_ofe = size_we & ~out_empty;
        err_ife = done & ~in_empty;
        inc     = in_push & ~err_ifo;
        dec     = in_pop & ~in_empty & (level_q != '0);
    end

    // Input word counter, saturating at both ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (inc && !dec)
            level_q <= level_q + 1'b1;
        else if (dec && !inc)
            level_q <= level_q - 1'b1;
    end
endmodule

// File: rtl/eu_err_status.sv
// Module: mask and sticky status registers. Unmasked errors set status bits;
// a clear write drops bits with a one in the write data; setting wins.
// Assumes the caller passes only the write-data bits aligned with the errors.
module eu_err_status
    import eu_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  err_vec_t err_in,
    input  logic     mask_we,
    input  logic     clr_we,
    input  err_vec_t sel_bits,
    output err_vec_t mask_o,
    output err_vec_t stat_o
);
    err_vec_t mask_q, stat_q, clr_bits;

    // Select bits to clear this cycle
    always_comb clr_bits = clr_we ? sel_bits : '0;

    // Mask register update
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= sel_bits;
    end

    // Sticky status: clear requested bits, then set new unmasked errors
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | (err_in & ~mask_q);
    end

    assign mask_o = mask_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/eu_err_ctrl.sv
// Module: top of the execution unit error detection controller. Joins the
// decoder, FIFO monitor and status store, and places the flags in the status word.
// Assumes all inputs are synchronous to clk.
module eu_err_ctrl
    import eu_err_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = STAT_W,
    parameter int MODE_W       = 3,
    parameter int MODE_MAX     = 4,
    parameter int BLK_BITS     = 64,
    parameter int IN_CAP_BYTES = 256,
    parameter int WORD_BYTES   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              in_push,
    input  logic              in_pop,
    input  logic              in_full,
    input  logic              in_empty,
    input  logic              out_push,
    input  logic              out_pop,
    input  logic              out_full,
    input  logic              out_empty,
    input  logic              done,
    output logic [STAT_W-1:0] status,
    output logic              err_irq,
    output logic              halt
);
    err_vec_t err_vec, mask_vis, stat_vec;
    logic     size_we, mask_we, clr_we;

    eu_reg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W),
        .MODE_MAX(MODE_MAX), .BLK_BITS(BLK_BITS)
    ) u_dec (
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .err_dse(err_vec[IX_DSE]), .err_me(err_vec[IX_ME]), .err_ae(err_vec[IX_AE]),
        .size_we(size_we), .mask_we(mask_we), .clr_we(clr_we)
    );

    eu_fifo_monitor #(
        .IN_CAP_BYTES(IN_CAP_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_push(in_push), .in_pop(in_pop), .in_full(in_full), .in_empty(in_empty),
        .out_push(out_push), .out_pop(out_pop), .out_full(out_full), .out_empty(out_empty),
        .done(done), .size_we(size_we),
        .err_ifu(err_vec[IX_IFU]), .err_ifo(err_vec[IX_IFO]),
        .err_ofu(err_vec[IX_OFU]), .err_ofo(err_vec[IX_OFO]),
        .err_ofe(err_vec[IX_OFE]), .err_ife(err_vec[IX_IFE])
    );

    eu_err_status u_stat (
        .clk(clk), .rst_n(rst_n), .err_in(err_vec),
        .mask_we(mask_we), .clr_we(clr_we),
        .sel_bits(reg_wdata[ERR_LSB +: ERR_N]),
        .mask_o(mask_vis), .stat_o(stat_vec)
    );

    // Place the error flags in the top of the status word; lower bits read zero
    always_comb begin
        status                   = '0;
        status[ERR_LSB +: ERR_N] = stat_vec;
        err_irq                  = |stat_vec;
        halt                     = |stat_vec;
    end
endmodule

// File: rtl/eu_err_ctrl_chk.sv
// Module: property checker for eu_err_ctrl, attached with bind.
// Assumes the mask register contents are brought out by the bind connection.
module eu_err_ctrl_chk
    import eu_err_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] A_STAT = 'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              in_push,
    input logic              in_pop,
    input logic              in_empty,
    input logic              out_push,
    input logic              out_pop,
    input logic              out_full,
    input logic              done,
    input logic [STAT_W-1:0] status,
    input logic              err_irq,
    input err_vec_t          mask
);
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_STAT) |=> ((status & $past(status)) == $past(status))); // R11
    AST_OFO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_push && out_full && !mask[IX_OFO]) |=> status[ERR_LSB + IX_OFO]); // R8
    AST_IFU_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop && in_empty && !mask[IX_IFU]) |=> status[ERR_LSB + IX_IFU]); // R7
    AST_IFE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !in_empty && !mask[IX_IFE]) |=> status[ERR_LSB + IX_IFE]); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[IX_AE] && !status[ERR_LSB + IX_AE]) |=> !status[ERR_LSB + IX_AE]); // R10
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(reg_wr || reg_rd || in_push || in_pop ||
                                 out_push || out_pop || done)); // R12
endmodule

bind eu_err_ctrl eu_err_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .in_push(in_push), .in_pop(in_pop), .in_empty(in_empty),
    .out_push(out_push), .out_pop(out_pop), .out_full(out_full), .done(done),
    .status(status), .err_irq(err_irq), .mask(mask_vis)
);

// File: tb/eu_err_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module eu_err_ctrl_tb_top;
    localparam logic [7:0] A_MODE = 8'h00, A_SIZE = 8'h08, A_MASK = 8'h10, A_STAT = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        in_push = 0, in_pop = 0, in_full = 0, in_empty = 1;
    logic        out_push = 0, out_pop = 0, out_full = 0, out_empty = 1;
    logic        done = 0;
    logic [63:0] status;
    logic        err_irq, halt;
    int          n_vec = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    eu_err_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .in_push(in_push), .in_pop(in_pop), .in_full(in_full), .in_empty(in_empty),
        .out_push(out_push), .out_pop(out_pop), .out_full(out_full), .out_empty(out_empty),
        .done(done), .status(status), .err_irq(err_irq), .halt(halt)
    );

    function automatic logic [63:0] bv(int b);
        return 64'(1) << b;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic clr_all();
        wr(A_STAT, '1);
    endtask

    task automatic t_reset();
        chk("R1 status", status, '0);
        chk("R1 irq/halt", {62'd0, err_irq, halt}, '0);
        wr(A_SIZE, 64'd100);
        chk("R1 nothing masked", status, bv(55));
        clr_all();
    endtask

    task automatic t_dse();
        wr(A_SIZE, 64'd128);
        chk("R2 aligned size", status, '0);
        wr(A_SIZE, 64'd100);
        chk("R2 unaligned size", status, bv(55));
        chk("R12 irq and halt up", {62'd0, err_irq, halt}, 64'd3);
        clr_all();
        chk("R12 irq and halt down", {62'd0, err_irq, halt}, '0);
    endtask

    task automatic t_mode();
        wr(A_MODE, 64'd4);
        chk("R3 legal mode", status, '0);
        wr(A_MODE, 64'd5);
        chk("R3 mode above limit", status, bv(56));
        clr_all();
        wr(A_MODE, bv(40) | 64'd1);
        chk("R3 reserved bit", status, bv(56));
        clr_all();
    endtask

    task automatic t_addr();
        rd(8'h20);
        chk("R4 bad read", status, bv(57));
        clr_all();
        wr(8'h09, 64'd0);
        chk("R4 bad write", status, bv(57));
        clr_all();
        rd(A_SIZE);
        rd(A_MASK);
        chk("R4 decoded reads", status, '0);
    endtask

    task automatic t_ofe();
        out_empty = 0;
        wr(A_SIZE, 64'd64);
        out_empty = 1;
        chk("R5 output busy at size write", status, bv(58));
        clr_all();
    endtask

    task automatic t_ife();
        in_empty = 0; done = 1;
        @(negedge clk);
        done = 0; in_empty = 1;
        chk("R6 input busy at done", status, bv(59));
        clr_all();
        done = 1;
        @(negedge clk);
        done = 0;
        chk("R6 done with empty input", status, '0);
    endtask

    task automatic t_uflow();
        in_pop = 1;
        @(negedge clk);
        in_pop = 0;
        chk("R7 input underflow", status, bv(60));
        out_pop = 1;
        @(negedge clk);
        out_pop = 0;
        chk("R7 output underflow", status, bv(60) | bv(62));
        clr_all();
    endtask

    task automatic t_oflow();
        out_push = 1; out_full = 1;
        @(negedge clk);
        out_push = 0; out_full = 0;
        chk("R8 output overflow", status, bv(63));
        clr_all();
        in_push = 1; in_full = 1;
        @(negedge clk);
        in_push = 0; in_full = 0;
        chk("R8 input overflow", status, bv(61));
        clr_all();
    endtask

    task automatic t_cap();
        in_push = 1;
        repeat (32) @(negedge clk);
        in_push = 0;
        chk("R9 32 words accepted", status, '0);
        in_push = 1;
        @(negedge clk);
        in_push = 0;
        chk("R9 push past 256 bytes", status, bv(61));
        clr_all();
        in_empty = 0; in_pop = 1;
        @(negedge clk);
        in_pop = 0;
        in_push = 1;
        @(negedge clk);
        in_push = 0; in_empty = 1;
        chk("R9 room after pop", status, '0);
    endtask

    task automatic t_mask();
        wr(A_MASK, bv(55) | bv(57));
        wr(A_SIZE, 64'd100);
        rd(8'h30);
        chk("R10 masked errors leave no bit", status, '0);
        chk("R10 masked errors raise no irq", {63'd0, err_irq}, '0);
        wr(A_MODE, 64'd7);
        chk("R10 unmasked still sets", status, bv(56));
        clr_all();
        wr(A_MASK, '0);
        wr(A_SIZE, 64'd100);
        chk("R10 unmask restores", status, bv(55));
        clr_all();
    endtask

    task automatic t_sticky();
        wr(A_MODE, 64'd6);
        repeat (5) @(negedge clk);
        chk("R11 bit stays set", status, bv(56));
        out_pop = 1;
        @(negedge clk);
        out_pop = 0;
        wr(A_STAT, bv(56));
        chk("R11 partial clear", status, bv(62));
        in_pop = 1;
        wr(A_STAT, '1);
        in_pop = 0;
        chk("R11 set wins over clear", status, bv(60));
        chk("R12 low bits zero", status & ((64'(1) << 55) - 1), '0);
        clr_all();
        chk("R11 all cleared", status, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_dse();
        t_mode();
        t_addr();
        t_ofe();
        t_ife();
        t_uflow();
        t_oflow();
        t_cap();
        t_mask();
        t_sticky();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule